// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This block sits between the address generation stage and the memory system of a 32-bit processor core. For every access it looks at the virtual address, the current privilege level, the error-level status bit and the read/write direction, and decides in the same cycle which of three paths the access takes. It can be translated through the TLB, passed straight through to a fixed physical window, or rejected as illegal for the current privilege level.

For direct windows the block forms the physical address itself and grants read and write permission. For translated windows it forwards the physical address and write permission that the TLB lookup reports. Every failure is turned into a 5-bit exception code and a refill flag that the exception logic uses to pick its handler. The block is purely combinational and holds no state.

Top module: `seg_addr_decoder`

## Requirements
- R1: With `erl` low, an address at or below 0x7FFFFFFF is translated (`tlb_used`=1). On a TLB hit (`tlb_res`=2'b00) `pa` equals `tlb_pa`, `rd_ok`=1 and `wr_ok` equals `tlb_wr_ok`. This holds in every privilege level.
- R2: With `erl` high, an address at or below 0x7FFFFFFF is passed through unchanged (`pa`=`va`) with `rd_ok`=`wr_ok`=1, `tlb_used`=0 and no fault, whatever `tlb_res` reports.
- R3: An address from 0x80000000 to 0x9FFFFFFF is legal only in kernel level. It is untranslated, with `pa` = `va` − 0x80000000 and read/write permission.
- R4: An address from 0xA0000000 to 0xBFFFFFFF is legal only in kernel level. It is untranslated, with `pa` = `va` − 0xA0000000 and read/write permission.
- R5: An address from 0xC0000000 to 0xDFFFFFFF is translated in supervisor or kernel level and is illegal in user level.
- R6: An address at or above 0xE0000000 is translated in kernel level only and is illegal in user and supervisor level.
- R7: An illegal access raises code 4 for a load (`is_store`=0) or code 5 for a store, with `refill`=0 and `tlb_used`=0, whatever `tlb_res` reports.
- R8: A translated access with a TLB miss (`tlb_res`=2'b01) raises code 2 for a load or code 3 for a store, with `refill`=1.
- R9: A translated access with a TLB invalid result (`tlb_res`=2'b10) raises code 2 for a load or code 3 for a store, with `refill`=0.
- R10: A translated access with a TLB dirty result (`tlb_res`=2'b11) raises code 1 for both directions, with `refill`=0.
- R11: `mode`=2'b10 is user level and `mode`=2'b01 is supervisor level. Both 2'b00 and 2'b11 are kernel level.
- R12: Without a fault, `fault`=0, `exc_code`=0 and `refill`=0. With a fault, `fault`=1, `pa`=0 and `rd_ok`=`wr_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va | input | 32 | Virtual address of the access |
| mode | input | 2 | Privilege level: 2'b10 user, 2'b01 supervisor, others kernel |
| erl | input | 1 | Error-level status bit; makes the low half of the space pass through untranslated |
| is_store | input | 1 | 1 for a write access, 0 for a read |
| tlb_res | input | 2 | TLB lookup outcome: 00 hit, 01 miss, 10 invalid, 11 dirty |
| tlb_pa | input | 32 | Physical address reported by the TLB on a hit |
| tlb_wr_ok | input | 1 | Write permission reported by the TLB on a hit |
| pa | output | 32 | Resulting physical address, zero on a fault |
| rd_ok | output | 1 | Read permission granted |
| wr_ok | output | 1 | Write permission granted |
| tlb_used | output | 1 | The access goes through translation, so the TLB result was consulted |
| fault | output | 1 | The access raises an exception |
| exc_code | output | 5 | Exception code, zero when there is no fault |
| refill | output | 1 | The fault is a TLB miss that calls for the refill handler |

## Verification
Two functions of the block can apply in the same cycle: the privilege check of a segment and the classification of the TLB outcome. The bench drives an illegal segment access together with each failing TLB result, and expects the address-error code (4 or 5) with refill clear, never a TLB code. The same holds for the error-level override: a low address with `erl` high is driven against every TLB outcome, including a miss, and is judged by `pa`=`va`, full permission and the absence of any fault.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int VA_W     = 32;
    localparam int ECODE_W  = 5;
    localparam int SEL_W    = 3;
    localparam int OFFS_W   = VA_W - SEL_W;

    typedef enum logic [1:0] {
        LVL_KERN_A = 2'b00,
        LVL_SUPV   = 2'b01,
        LVL_USER   = 2'b10,
        LVL_KERN_B = 2'b11
    } priv_lvl_e;

    typedef enum logic [1:0] {
        XL_HIT     = 2'b00,
        XL_MISS    = 2'b01,
        XL_INVALID = 2'b10,
        XL_DIRTY   = 2'b11
    } xlat_res_e;

    typedef enum logic [1:0] {
        ROUTE_XLAT    = 2'b00,
        ROUTE_DIRECT  = 2'b01,
        ROUTE_ILLEGAL = 2'b10
    } route_e;

    localparam logic [ECODE_W-1:0] EC_NONE  = 5'd0;
    localparam logic [ECODE_W-1:0] EC_MOD   = 5'd1;
    localparam logic [ECODE_W-1:0] EC_XL_LD = 5'd2;
    localparam logic [ECODE_W-1:0] EC_XL_ST = 5'd3;
    localparam logic [ECODE_W-1:0] EC_AD_LD = 5'd4;
    localparam logic [ECODE_W-1:0] EC_AD_ST = 5'd5;

endpackage

// File: rtl/seg_route.sv
module seg_route
    import seg_addr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       mode,
    input  logic             erl,
    output route_e           route
);
    logic lvl_user;
    logic lvl_supv;
    logic lvl_kern;

    always_comb begin
        lvl_user = (mode == LVL_USER);
        lvl_supv = (mode == LVL_SUPV);
        lvl_kern = !lvl_user && !lvl_supv;
    end

    always_comb begin
        route = ROUTE_ILLEGAL;
        unique casez (sel)
            3'b0??: route = erl ? ROUTE_DIRECT : ROUTE_XLAT;
            3'b100,
            3'b101: route = lvl_kern ? ROUTE_DIRECT : ROUTE_ILLEGAL;
            3'b110: route = (lvl_kern || lvl_supv) ? ROUTE_XLAT : ROUTE_ILLEGAL;
            3'b111: route = lvl_kern ? ROUTE_XLAT : ROUTE_ILLEGAL;
            default: route = ROUTE_ILLEGAL;
        endcase
    end

    always_comb begin
        if (!$isunknown({sel, mode, erl})) begin
            a_r11_user_no_kernel_window: assert (!(lvl_user && !sel[SEL_W-1] == 1'b0 && route != ROUTE_ILLEGAL));
            a_r6_top_window_kernel_only: assert (!(sel == 3'b111 && !lvl_kern && route != ROUTE_ILLEGAL));
        end
    end
endmodule

// File: rtl/seg_direct_pa.sv
module seg_direct_pa
    import seg_addr_pkg::*;
(
    input  logic [VA_W-1:0] va,
    output logic [VA_W-1:0] direct_pa
);
    always_comb begin
        if (va[VA_W-1]) begin
            direct_pa = {{SEL_W{1'b0}}, va[OFFS_W-1:0]};
        end else begin
            direct_pa = va;
        end
    end
endmodule

// File: rtl/seg_fault_map.sv
module seg_fault_map
    import seg_addr_pkg::*;
(
    input  route_e              route,
    input  logic [1:0]          tlb_res,
    input  logic                is_store,
    input  logic [VA_W-1:0]     direct_pa,
    input  logic [VA_W-1:0]     tlb_pa,
    input  logic                tlb_wr_ok,
    output logic [VA_W-1:0]     pa,
    output logic                rd_ok,
    output logic                wr_ok,
    output logic                fault,
    output logic [ECODE_W-1:0]  exc_code,
    output logic                refill
);
    always_comb begin
        pa       = '0;
        rd_ok    = 1'b0;
        wr_ok    = 1'b0;
        fault    = 1'b1;
        exc_code = EC_NONE;
        refill   = 1'b0;
        unique case (route)
            ROUTE_DIRECT: begin
                pa    = direct_pa;
                rd_ok = 1'b1;
                wr_ok = 1'b1;
                fault = 1'b0;
            end
            ROUTE_ILLEGAL: begin
                exc_code = is_store ? EC_AD_ST : EC_AD_LD;
            end
            default: begin
                unique case (tlb_res)
                    XL_HIT: begin
                        pa    = tlb_pa;
                        rd_ok = 1'b1;
                        wr_ok = tlb_wr_ok;
                        fault = 1'b0;
                    end
                    XL_MISS: begin
                        exc_code = is_store ? EC_XL_ST : EC_XL_LD;
                        refill   = 1'b1;
                    end
                    XL_INVALID: begin
                        exc_code = is_store ? EC_XL_ST : EC_XL_LD;
                    end
                    default: begin
                        exc_code = EC_MOD;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
    import seg_addr_pkg::*;
(
    input  logic [31:0] va,
    input  logic [1:0]  mode,
    input  logic        erl,
    input  logic        is_store,
    input  logic [1:0]  tlb_res,
    input  logic [31:0] tlb_pa,
    input  logic        tlb_wr_ok,
    output logic [31:0] pa,
    output logic        rd_ok,
    output logic        wr_ok,
    output logic        tlb_used,
    output logic        fault,
    output logic [4:0]  exc_code,
    output logic        refill
);
    route_e          route;
    logic [VA_W-1:0] direct_pa;

    seg_route u_route (
        .sel   (va[VA_W-1 -: SEL_W]),
        .mode  (mode),
        .erl   (erl),
        .route (route)
    );

    seg_direct_pa u_direct (
        .va        (va),
        .direct_pa (direct_pa)
    );

    seg_fault_map u_fault (
        .route     (route),
        .tlb_res   (tlb_res),
        .is_store  (is_store),
        .direct_pa (direct_pa),
        .tlb_pa    (tlb_pa),
        .tlb_wr_ok (tlb_wr_ok),
        .pa        (pa),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .fault     (fault),
        .exc_code  (exc_code),
        .refill    (refill)
    );

    always_comb tlb_used = (route == ROUTE_XLAT);

    always_comb begin
        if (!$isunknown({va, mode, erl, is_store, tlb_res, tlb_pa, tlb_wr_ok})) begin
            a_r12_fault_blocks_access: assert (!fault || (pa == '0 && !rd_ok && !wr_ok));
            a_r12_quiet_code: assert (fault || (exc_code == EC_NONE && !refill));
            a_r2_erl_low_half_clean: assert (!(erl && !va[31]) || (!fault && !tlb_used && pa == va));
            a_r7_illegal_addr_code: assert (!(fault && !tlb_used) || (exc_code == (is_store ? EC_AD_ST : EC_AD_LD) && !refill));
            a_r8_refill_only_on_miss: assert (!refill || (tlb_used && tlb_res == XL_MISS));
            a_r3_direct_window_low: assert (!(va[31] && !tlb_used && !fault) || pa[31:29] == 3'b000);
        end
    end
endmodule

// File: tb/seg_addr_decoder_tb_top.sv
module seg_addr_decoder_tb_top;

    typedef struct {
        logic [31:0] va;
        logic [1:0]  mode;
        logic        erl;
        logic        st;
        logic [1:0]  res;
        logic [31:0] tpa;
        logic        twr;
        logic [31:0] pa;
        logic        rd;
        logic        wr;
        logic        used;
        logic        flt;
        logic [4:0]  code;
        logic        rf;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] va = '0;
    logic [1:0]  mode = 2'b00;
    logic        erl = 1'b0;
    logic        is_store = 1'b0;
    logic [1:0]  tlb_res = 2'b00;
    logic [31:0] tlb_pa = '0;
    logic        tlb_wr_ok = 1'b0;
    logic [31:0] pa;
    logic        rd_ok, wr_ok, tlb_used, fault, refill;
    logic [4:0]  exc_code;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    seg_addr_decoder dut_i (
        .va(va), .mode(mode), .erl(erl), .is_store(is_store),
        .tlb_res(tlb_res), .tlb_pa(tlb_pa), .tlb_wr_ok(tlb_wr_ok),
        .pa(pa), .rd_ok(rd_ok), .wr_ok(wr_ok), .tlb_used(tlb_used),
        .fault(fault), .exc_code(exc_code), .refill(refill)
    );

    // Reference model written from the requirement list
    function automatic item_t model(logic [31:0] a, logic [1:0] m, logic e,
                                    logic s, logic [1:0] r, logic [31:0] tp, logic tw);
        item_t it;
        bit is_user, is_sup, is_kern, legal, xlat;
        string seg;
        it.va = a; it.mode = m; it.erl = e; it.st = s; it.res = r; it.tpa = tp; it.twr = tw;
        is_user = (m == 2'b10);            // R11
        is_sup  = (m == 2'b01);            // R11
        is_kern = !(is_user || is_sup);    // R11
        it.pa = 0; it.rd = 0; it.wr = 0; it.used = 0; it.flt = 0; it.code = 0; it.rf = 0;
        if (a <= 32'h7FFF_FFFF) begin
            xlat = !e; legal = 1; seg = e ? "R2" : "R1";
        end else if (a < 32'hA000_0000) begin
            xlat = 0; legal = is_kern; seg = "R3";
        end else if (a < 32'hC000_0000) begin
            xlat = 0; legal = is_kern; seg = "R4";
        end else if (a < 32'hE000_0000) begin
            xlat = 1; legal = !is_user; seg = "R5";
        end else begin
            xlat = 1; legal = is_kern; seg = "R6";
        end
        if (!legal) begin
            it.flt = 1; it.code = s ? 5 : 4; it.tag = {seg, "/R7"};
        end else if (!xlat) begin
            it.rd = 1; it.wr = 1;
            if (a <= 32'h7FFF_FFFF) it.pa = a;
            else if (a < 32'hA000_0000) it.pa = a - 32'h8000_0000;
            else it.pa = a - 32'hA000_0000;
            it.tag = {seg, "/R12"};
        end else begin
            it.used = 1;
            case (r)
                2'b00: begin it.pa = tp; it.rd = 1; it.wr = tw; it.tag = {seg, "/R12"}; end
                2'b01: begin it.flt = 1; it.code = s ? 3 : 2; it.rf = 1; it.tag = {seg, "/R8"}; end
                2'b10: begin it.flt = 1; it.code = s ? 3 : 2; it.tag = {seg, "/R9"}; end
                default: begin it.flt = 1; it.code = 1; it.tag = {seg, "/R10"}; end
            endcase
        end
        return it;
    endfunction

    task automatic drive(logic [31:0] a, logic [1:0] m, logic e, logic s,
                         logic [1:0] r, logic [31:0] tp, logic tw, string extra);
        item_t it;
        @(posedge clk);
        #1;
        va = a; mode = m; erl = e; is_store = s; tlb_res = r; tlb_pa = tp; tlb_wr_ok = tw;
        it = model(a, m, e, s, r, tp, tw);
        if (extra != "") it.tag = {extra, " ", it.tag};
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (pa !== it.pa || rd_ok !== it.rd || wr_ok !== it.wr || tlb_used !== it.used ||
                fault !== it.flt || exc_code !== it.code || refill !== it.rf) begin
                n_fail++;
                $display("FAIL %s va=%h mode=%b erl=%b st=%b res=%b: got pa=%h rd=%b wr=%b used=%b flt=%b code=%0d rf=%b exp pa=%h rd=%b wr=%b used=%b flt=%b code=%0d rf=%b",
                         it.tag, it.va, it.mode, it.erl, it.st, it.res,
                         pa, rd_ok, wr_ok, tlb_used, fault, exc_code, refill,
                         it.pa, it.rd, it.wr, it.used, it.flt, it.code, it.rf);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] vas [10];
        vas = '{32'h0000_0000, 32'h1234_5678, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
                32'hA000_0000, 32'hBFFF_FFFC, 32'hC000_0000, 32'hDFFF_FFFF, 32'hFFFF_FFFF};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset state: all-zero inputs, kernel level, hit with no write right
        drive(32'h0, 2'b00, 0, 0, 2'b00, 32'h0, 0, "reset-state R1");
        // R1 hit forwards TLB address and write right
        drive(32'h0040_1000, 2'b10, 0, 1, 2'b00, 32'h1F00_2000, 1, "R1 user hit");
        drive(32'h0040_1000, 2'b10, 0, 0, 2'b00, 32'h0ABC_D000, 0, "R1 user hit ro");
        // R2 erl override against a miss
        drive(32'h7FFF_FFFF, 2'b10, 1, 1, 2'b01, 32'hDEAD_BEEF, 0, "R2 erl vs miss");
        drive(32'h0000_1234, 2'b01, 1, 0, 2'b11, 32'h0, 0, "R2 erl vs dirty");
        // R3 / R4 window edges
        drive(32'h8000_0000, 2'b00, 0, 0, 2'b01, 32'h0, 0, "R3 low edge");
        drive(32'h9FFF_FFFF, 2'b11, 0, 1, 2'b10, 32'h0, 0, "R3 high edge kern-b R11");
        drive(32'hA000_0000, 2'b00, 0, 0, 2'b00, 32'h0, 0, "R4 low edge");
        drive(32'hBFFF_FFFF, 2'b00, 1, 1, 2'b00, 32'h0, 0, "R4 high edge erl");
        // R7 illegal combined with TLB failures
        drive(32'h8000_0010, 2'b10, 0, 0, 2'b01, 32'h0, 0, "R7 user kseg miss");
        drive(32'hA000_0010, 2'b01, 0, 1, 2'b11, 32'h0, 1, "R7 supv direct store");
        drive(32'hC000_0000, 2'b10, 0, 1, 2'b01, 32'h0, 0, "R5 R7 user");
        drive(32'hE000_0000, 2'b01, 0, 0, 2'b00, 32'h5555_0000, 1, "R6 R7 supv");
        // R5 / R6 legal translation
        drive(32'hDFFF_FFFF, 2'b01, 0, 0, 2'b00, 32'h0123_4000, 1, "R5 supv hit");
        drive(32'hE000_0000, 2'b11, 0, 1, 2'b00, 32'h0765_4000, 1, "R6 kern-b hit");
        // R8 / R9 / R10
        drive(32'h0000_2000, 2'b10, 0, 0, 2'b01, 32'h0, 0, "R8 load miss");
        drive(32'h0000_2000, 2'b10, 0, 1, 2'b01, 32'h0, 0, "R8 store miss");
        drive(32'hC100_0000, 2'b00, 0, 0, 2'b10, 32'h0, 0, "R9 load invalid");
        drive(32'hF000_0000, 2'b00, 0, 1, 2'b10, 32'h0, 0, "R9 store invalid");
        drive(32'h0000_3000, 2'b00, 0, 0, 2'b11, 32'h0, 0, "R10 dirty load");
        drive(32'h0000_3000, 2'b00, 0, 1, 2'b11, 32'h0, 0, "R10 dirty store");

        // exhaustive sweep over edges, levels, erl, direction and TLB outcome
        for (int i = 0; i < 10; i++)
            for (int m = 0; m < 4; m++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++)
                        for (int r = 0; r < 4; r++)
                            drive(vas[i], 2'(m), 1'(e), 1'(s), 2'(r),
                                  32'h3000_0000 + 32'(i * 4096), 1'(r[0] ^ s[0]), "sweep R11");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule